// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between an on-chip master and an external asynchronous static RAM of 256K words by 16 bits. The master offers one word access at a time on a valid/ready request port: address, a write flag, write data and a two-bit byte mask. The controller turns each accepted request into a bus cycle on the RAM pins. It drives the address, two chip selects of opposite polarity, an active-low output enable, an active-low write enable and one active-low select per byte lane. A read returns its data on a single-cycle response strobe.

Every phase of a cycle lasts a whole number of clocks. Each count is the ceiling of a RAM timing figure divided by the clock-period parameter, and is never less than one clock. The phases are read access, bus turnaround after a read, write pulse and write recovery. The shared data bus appears as three separate signals: output value, output enable and input value. A pad cell outside the block joins them into the three-state pin. When no access is running, the RAM is held deselected.

Top module: `sram_async_ctrl`

## Requirements
- R1: With no access in progress, the pins sit at their idle levels: first select high, second select low, output enable high, write enable high, both byte selects high and data driver off. `req_ready` is high only in that state, and the same idle state holds during reset.
- R2: A read asserts the chip selects (first low, second high) with output enable low and write enable high. It holds the address for RD_CYC clocks, where RD_CYC is the larger of ceil(45 ns / Tclk) and the 45 ns read cycle in clocks. That is 3 clocks at 20 ns.
- R3: Read data is registered on the last read clock. `rsp_valid` is high for exactly one clock, in the clock after the last read clock. Mask bit 0 covers bits 7:0 and bit 1 covers bits 15:8. A lane whose mask bit is 0 has its select left high and returns zero.
- R4: After a read, the RAM stays deselected for ceil(18 ns / Tclk) clocks (1 at 20 ns) before `req_ready` rises again.
- R5: A write holds write enable low with output enable high for WP_CYC clocks. WP_CYC is the larger of ceil(35 ns / Tclk) and the driver delay plus ceil(25 ns / Tclk), which is 3 at 20 ns. The byte selects follow the mask, and mask bit 0 selects the lower lane.
- R6: The data driver turns on ceil(18 ns / Tclk) clocks after write enable falls. It turns off one clock after write enable rises. It is never on while output enable is low or while the RAM may still be driving the bus.
- R7: At the end of each write, the data has been driven and stable for at least 25 ns and the write pulse has lasted at least 35 ns. Only the selected lanes are updated in the RAM.
- R8: An accepted request with mask 0 is a no-op. No pin leaves idle, no response is produced, and `req_ready` stays high.
- R9: A request is taken only on a clock where `req_valid` and `req_ready` are both high. Its fields are captured at that edge, so later changes to the request inputs do not affect the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte mask, bit 0 lower lane, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 18 | RAM address |
| sram_cs1_n | output | 1 | Chip select, active low |
| sram_cs2 | output | 1 | Chip select, active high |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_bs_n | output | 2 | Byte selects, active low, bit 0 lower lane |
| sram_dq_o | output | 16 | Data value toward the pad |
| sram_dq_oe | output | 1 | Pad driver enable |
| sram_dq_i | input | 16 | Data value from the pad |

## Verification
All pins are registered, so a read accepted at clock edge E0 shows its pins after E0. `rsp_valid` is high after edge E(RD_CYC), and `req_ready` returns after E(RD_CYC+TA_CYC). A write shows write enable low after E0 and the driver on after E(1), with recovery after E(WP_CYC) and ready after E(WP_CYC+REC_CYC). The bench samples on the falling edge and numbers each falling edge from the accepting edge, so every pin and response is compared on the exact falling edge where it is due. A RAM model running in 1 ns steps returns junk until 45 ns of stable read enables have passed. It also measures the write pulse and the data setup, and flags any overlap of drivers.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD     = 3'd1,
    ST_RD_TA  = 3'd2,
    ST_WR     = 3'd3,
    ST_WR_REC = 3'd4
  } phase_e;

  // clocks needed to cover a time, never fewer than one
  function automatic int unsigned t2cyc(int unsigned t_ps, int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_seq.sv
`timescale 1ns/1ps
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC  = 3,
  parameter int unsigned TA_CYC  = 1,
  parameter int unsigned WP_CYC  = 3,
  parameter int unsigned REC_CYC = 1,
  parameter int unsigned CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rd,
  input  logic             start_wr,
  output phase_e           ph_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic             idle,
  output logic             rd_last
);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_m1;
  logic             last;

  always_comb begin
    case (ph_q)
      ST_RD:     len_m1 = CNT_W'(RD_CYC - 1);
      ST_RD_TA:  len_m1 = CNT_W'(TA_CYC - 1);
      ST_WR:     len_m1 = CNT_W'(WP_CYC - 1);
      ST_WR_REC: len_m1 = CNT_W'(REC_CYC - 1);
      default:   len_m1 = '0;
    endcase
  end

  assign last    = (cnt_q == len_m1);
  assign idle    = (ph_q == ST_IDLE);
  assign rd_last = (ph_q == ST_RD) && last;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q + 1'b1;
    case (ph_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_rd)      ph_d = ST_RD;
        else if (start_wr) ph_d = ST_WR;
      end
      ST_RD: if (last) begin
        ph_d  = ST_RD_TA;
        cnt_d = '0;
      end
      ST_RD_TA: if (last) begin
        ph_d  = ST_IDLE;
        cnt_d = '0;
      end
      ST_WR: if (last) begin
        ph_d  = ST_WR_REC;
        cnt_d = '0;
      end
      ST_WR_REC: if (last) begin
        ph_d  = ST_IDLE;
        cnt_d = '0;
      end
      default: begin
        ph_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd || start_wr) |-> (ph_q == ST_IDLE)); // R9
  AST_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_rd && start_wr)); // R9

endmodule

// File: rtl/sram_pin_drv.sv
`timescale 1ns/1ps
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW      = 18,
  parameter int unsigned DW      = 16,
  parameter int unsigned BE_W    = 2,
  parameter int unsigned CNT_W   = 2,
  parameter int unsigned DRV_DLY = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    ld_addr,
  input  logic [BE_W-1:0]  ld_be,
  input  logic [DW-1:0]    ld_wdata,
  input  phase_e           ph_d,
  input  logic [CNT_W-1:0] cnt_d,
  output logic [AW-1:0]    sram_addr,
  output logic             sram_cs1_n,
  output logic             sram_cs2,
  output logic             sram_oe_n,
  output logic             sram_we_n,
  output logic [BE_W-1:0]  sram_bs_n,
  output logic [DW-1:0]    sram_dq_o,
  output logic             sram_dq_oe
);

  logic [AW-1:0]   addr_q;
  logic [BE_W-1:0] be_q;
  logic [DW-1:0]   wd_q;
  logic [BE_W-1:0] be_nx;
  logic            rd_on, wr_on, sel;
  logic            cs1_n_d, cs2_d, oe_n_d, we_n_d, dq_oe_d;
  logic [BE_W-1:0] bs_n_d;

  // request capture, clock enable = load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
    end else if (load) begin
      addr_q <= ld_addr;
      be_q   <= ld_be;
      wd_q   <= ld_wdata;
    end
  end

  assign be_nx = load ? ld_be : be_q;

  always_comb begin
    rd_on   = (ph_d == ST_RD);
    wr_on   = (ph_d == ST_WR);
    sel     = rd_on || wr_on;
    cs1_n_d = ~sel;
    cs2_d   = sel;
    oe_n_d  = ~rd_on;
    we_n_d  = ~wr_on;
    bs_n_d  = sel ? ~be_nx : '1;
    dq_oe_d = (wr_on && (cnt_d >= CNT_W'(DRV_DLY))) ||
              ((ph_d == ST_WR_REC) && (cnt_d == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_cs1_n <= 1'b1;
      sram_cs2   <= 1'b0;
      sram_oe_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_bs_n  <= '1;
      sram_dq_oe <= 1'b0;
    end else begin
      sram_cs1_n <= cs1_n_d;
      sram_cs2   <= cs2_d;
      sram_oe_n  <= oe_n_d;
      sram_we_n  <= we_n_d;
      sram_bs_n  <= bs_n_d;
      sram_dq_oe <= dq_oe_d;
    end
  end

  assign sram_addr = addr_q;
  assign sram_dq_o = wd_q;

  AST_NO_DRIVE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n); // R6
  AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (!sram_we_n && $past(!sram_we_n))); // R6
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n); // R5
  AST_DRIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |=> !sram_dq_oe); // R6

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int unsigned DW   = 16,
  parameter int unsigned BE_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap,
  input  logic [BE_W-1:0] lane_en,
  input  logic [DW-1:0]   dq_i,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);

  localparam int unsigned LANE_W = DW / BE_W;

  logic [DW-1:0] rdata_d;

  for (genvar l = 0; l < BE_W; l++) begin : g_lane
    assign rdata_d[l*LANE_W +: LANE_W] =
      lane_en[l] ? dq_i[l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= cap;
      if (cap) rdata <= rdata_d;
    end
  end

  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid); // R3

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW      = 18,
  parameter int unsigned DW      = 16,
  parameter int unsigned CLK_PS  = 20000,
  parameter int unsigned T_AA_PS = 45000,
  parameter int unsigned T_RC_PS = 45000,
  parameter int unsigned T_WC_PS = 45000,
  parameter int unsigned T_WP_PS = 35000,
  parameter int unsigned T_DS_PS = 25000,
  parameter int unsigned T_HZ_PS = 18000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW/8-1:0]     req_be,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_valid,
  output logic [DW-1:0]       rsp_rdata,
  output logic [AW-1:0]       sram_addr,
  output logic                sram_cs1_n,
  output logic                sram_cs2,
  output logic                sram_oe_n,
  output logic                sram_we_n,
  output logic [DW/8-1:0]     sram_bs_n,
  output logic [DW-1:0]       sram_dq_o,
  output logic                sram_dq_oe,
  input  logic [DW-1:0]       sram_dq_i
);

  localparam int unsigned BE_W    = DW / 8;
  localparam int unsigned RD_CYC  = umax(t2cyc(T_AA_PS, CLK_PS), t2cyc(T_RC_PS, CLK_PS));
  localparam int unsigned TA_CYC  = t2cyc(T_HZ_PS, CLK_PS);
  localparam int unsigned DRV_DLY = t2cyc(T_HZ_PS, CLK_PS);
  localparam int unsigned WP_CYC  = umax(t2cyc(T_WP_PS, CLK_PS),
                                         DRV_DLY + t2cyc(T_DS_PS, CLK_PS));
  localparam int unsigned WC_CYC  = t2cyc(T_WC_PS, CLK_PS);
  localparam int unsigned REC_CYC = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC) : 1;
  localparam int unsigned MAX_LEN = umax(umax(RD_CYC, TA_CYC), umax(WP_CYC, REC_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic             rst_sync_q0, rst_sync_q1, rst_ni;
  logic             accept, start_rd, start_wr, seq_idle, rd_last;
  phase_e           ph_d;
  logic [CNT_W-1:0] cnt_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q0 <= 1'b0;
      rst_sync_q1 <= 1'b0;
    end else begin
      rst_sync_q0 <= 1'b1;
      rst_sync_q1 <= rst_sync_q0;
    end
  end
  assign rst_ni = rst_sync_q1;

  assign req_ready = seq_idle;
  assign accept    = req_valid && req_ready;
  assign start_rd  = accept && !req_write && (|req_be);
  assign start_wr  = accept &&  req_write && (|req_be);

  sram_phase_seq #(
    .RD_CYC (RD_CYC),
    .TA_CYC (TA_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .CNT_W  (CNT_W)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_ni),
    .start_rd(start_rd),
    .start_wr(start_wr),
    .ph_d    (ph_d),
    .cnt_d   (cnt_d),
    .idle    (seq_idle),
    .rd_last (rd_last)
  );

  sram_pin_drv #(
    .AW     (AW),
    .DW     (DW),
    .BE_W   (BE_W),
    .CNT_W  (CNT_W),
    .DRV_DLY(DRV_DLY)
  ) pins_i (
    .clk       (clk),
    .rst_n     (rst_ni),
    .load      (start_rd || start_wr),
    .ld_addr   (req_addr),
    .ld_be     (req_be),
    .ld_wdata  (req_wdata),
    .ph_d      (ph_d),
    .cnt_d     (cnt_d),
    .sram_addr (sram_addr),
    .sram_cs1_n(sram_cs1_n),
    .sram_cs2  (sram_cs2),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n),
    .sram_bs_n (sram_bs_n),
    .sram_dq_o (sram_dq_o),
    .sram_dq_oe(sram_dq_oe)
  );

  sram_rd_capture #(
    .DW  (DW),
    .BE_W(BE_W)
  ) cap_i (
    .clk    (clk),
    .rst_n  (rst_ni),
    .cap    (rd_last),
    .lane_en(~sram_bs_n),
    .dq_i   (sram_dq_i),
    .rdata  (rsp_rdata),
    .rvalid (rsp_valid)
  );

  // run-length counters used only by the checks below
  logic [7:0] rd_run, wr_run;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_run <= '0;
      wr_run <= '0;
    end else begin
      rd_run <= sram_oe_n ? 8'd0 : rd_run + 8'd1;
      wr_run <= sram_we_n ? 8'd0 : wr_run + 8'd1;
    end
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_ni)
    req_ready |-> (sram_cs1_n && !sram_cs2 && sram_oe_n && sram_we_n &&
                   (&sram_bs_n) && !sram_dq_oe)); // R1
  AST_RD_LEN: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(sram_oe_n) |-> (rd_run == 8'(RD_CYC))); // R2
  AST_WR_LEN: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(sram_we_n) |-> (wr_run == 8'(WP_CYC))); // R5
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready && (req_be == '0)) |=> req_ready); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (!sram_cs1_n && $past(!sram_cs1_n)) |-> $stable(sram_addr)); // R9

endmodule

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;

  // expected phase lengths, worked from the requirements at a 20 ns clock
  localparam int CLK_NS = 20;
  function automatic int cyc(int t);
    int c;
    c = (t + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int E_RD  = (cyc(45) > cyc(45)) ? cyc(45) : cyc(45);
  localparam int E_TA  = cyc(18);
  localparam int E_DLY = cyc(18);
  localparam int E_WP  = (cyc(35) > E_DLY + cyc(25)) ? cyc(35) : E_DLY + cyc(25);
  localparam int E_REC = (cyc(45) > E_WP + 1) ? cyc(45) - E_WP : 1;
  localparam logic [6:0] IDLE_CTL = 7'b1011110; // cs1_n,cs2,oe_n,we_n,bs_n[1:0],dq_oe

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [17:0] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] sram_addr;
  logic        sram_cs1_n, sram_cs2, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [1:0]  sram_bs_n;
  logic [15:0] sram_dq_o, sram_dq_i;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_bs_n(sram_bs_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] ctl_now();
    return {sram_cs1_n, sram_cs2, sram_oe_n, sram_we_n, sram_bs_n, sram_dq_oe};
  endfunction

  // ---------------- RAM model, 1 ns steps between clock edges ----------------
  logic [15:0] model_mem [0:1023];
  int  now_ns = 0, rd_age = 0, hold_ns = 1000, drv_age = 0, wr_t0 = 0, contention = 0;
  bit  rd_prev = 0, wr_prev = 0, oe_prev = 0;
  logic [17:0] rd_a_prev;
  logic [1:0]  rd_bs_prev;
  logic [15:0] dq_prev;
  logic [17:0] wl_addr;
  logic [1:0]  wl_bs;
  logic [15:0] wl_data;
  bit          wl_drv;
  int          wl_age;

  initial begin
    for (int i = 0; i < 1024; i++) model_mem[i] = 16'h0000;
    sram_dq_i = 16'hC3C3;
    #0.5;
    forever begin
      bit rd_en, wr_act;
      rd_en  = !sram_cs1_n && sram_cs2 && sram_we_n && !sram_oe_n && (sram_bs_n != 2'b11);
      wr_act = !sram_cs1_n && sram_cs2 && !sram_we_n && (sram_bs_n != 2'b11);
      if (rd_en && rd_prev && sram_addr == rd_a_prev && sram_bs_n == rd_bs_prev) rd_age++;
      else rd_age = 0;
      if (rd_en) hold_ns = 0; else if (hold_ns < 1000) hold_ns++;
      if ((rd_en || hold_ns < 18) && sram_dq_oe) contention++;
      for (int l = 0; l < 2; l++) begin
        if (rd_en && !sram_bs_n[l] && rd_age >= 45)
          sram_dq_i[l*8 +: 8] = model_mem[sram_addr[9:0]][l*8 +: 8];
        else
          sram_dq_i[l*8 +: 8] = (rd_en && !sram_bs_n[l]) ? 8'hC3 : 8'hA5;
      end
      if (sram_dq_oe && oe_prev && sram_dq_o == dq_prev) drv_age++;
      else drv_age = 0;
      if (wr_act && !wr_prev) wr_t0 = now_ns;
      if (wr_act) begin
        wl_addr = sram_addr; wl_bs = sram_bs_n; wl_data = sram_dq_o;
        wl_drv = sram_dq_oe; wl_age = drv_age;
      end
      if (!wr_act && wr_prev) begin
        check(now_ns - wr_t0 >= 35, "R7 write pulse ns", now_ns - wr_t0, 35);
        check(wl_drv && wl_age >= 25, "R7 data setup ns", wl_drv ? wl_age : -1, 25);
        for (int l = 0; l < 2; l++)
          if (!wl_bs[l]) model_mem[wl_addr[9:0]][l*8 +: 8] = wl_data[l*8 +: 8];
      end
      rd_prev = rd_en; rd_a_prev = sram_addr; rd_bs_prev = sram_bs_n;
      wr_prev = wr_act; oe_prev = sram_dq_oe; dq_prev = sram_dq_o;
      now_ns++;
      #1;
    end
  end

  // ---------------- request driver ----------------
  logic [15:0] shadow [0:1023];
  logic [6:0]  snap_ctl [0:15];
  logic [17:0] snap_addr [0:15];
  logic [15:0] snap_dq [0:15];

  task automatic access(input bit w, input logic [17:0] a, input logic [1:0] be,
                        input logic [15:0] d, output logic [15:0] rd,
                        output int rv_at, output int rdy_at);
    rv_at = 0; rdy_at = 0; rd = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~d;
    for (int k = 1; k < 16; k++) begin
      snap_ctl[k] = ctl_now(); snap_addr[k] = sram_addr; snap_dq[k] = sram_dq_o;
      if (rsp_valid && rv_at == 0) begin rv_at = k; rd = rsp_rdata; end
      if (req_ready && rdy_at == 0) rdy_at = k;
      if (rdy_at != 0) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic do_write(input logic [17:0] a, input logic [1:0] be, input logic [15:0] d,
                          input bit pins);
    logic [15:0] rd;
    int rv, rdy;
    access(1'b1, a, be, d, rd, rv, rdy);
    check(rdy == E_WP + E_REC + 1, "R5 write ready return", rdy, E_WP + E_REC + 1);
    check(rv == 0, "R3 no response on write", rv, 0);
    shadow[a[9:0]] = (shadow[a[9:0]] & ~lane_mask(be)) | (d & lane_mask(be));
    if (pins) begin
      check(snap_ctl[1] == {2'b01, 2'b10, ~be, 1'b0}, "R5 write pins", snap_ctl[1], {2'b01, 2'b10, ~be, 1'b0});
      check(snap_ctl[1 + E_DLY][0] == 1'b1 && snap_dq[1 + E_DLY] == d, "R6 driver on with data",
            snap_dq[1 + E_DLY], d);
      check(snap_ctl[E_WP + 1] == 7'b1011111, "R6 driver held one clock past we", snap_ctl[E_WP + 1], 7'b1011111);
      check(snap_ctl[E_WP + 2] == IDLE_CTL, "R1 idle after write", snap_ctl[E_WP + 2], IDLE_CTL);
      check(snap_addr[1] == a, "R5 write address", snap_addr[1], a);
    end
  endtask

  task automatic do_read(input logic [17:0] a, input logic [1:0] be, input bit pins);
    logic [15:0] rd, exp;
    int rv, rdy;
    access(1'b0, a, be, 16'h0000, rd, rv, rdy);
    exp = shadow[a[9:0]] & lane_mask(be);
    check(rv == E_RD + 1, "R3 response timing", rv, E_RD + 1);
    check(rd == exp, "R3 read data lanes", rd, exp);
    check(rdy == E_RD + E_TA + 1, "R4 ready after turnaround", rdy, E_RD + E_TA + 1);
    if (pins) begin
      for (int k = 1; k <= E_RD; k++)
        check(snap_ctl[k] == {2'b01, 2'b01, ~be, 1'b0} && snap_addr[k] == a, "R2 read pins",
              snap_ctl[k], {2'b01, 2'b01, ~be, 1'b0});
      check(snap_ctl[E_RD + 1] == IDLE_CTL, "R4 deselected in turnaround", snap_ctl[E_RD + 1], IDLE_CTL);
    end
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [15:0] rd;
    int rv, rdy, we_lo;
    for (int i = 0; i < 1024; i++) shadow[i] = 16'h0000;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_be = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(ctl_now() == IDLE_CTL, "R1 pins in reset", ctl_now(), IDLE_CTL);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ctl_now() == IDLE_CTL && req_ready, "R1 idle after reset", {ctl_now(), req_ready}, {IDLE_CTL, 1'b1});

    // full-word writes then reads over 32 addresses
    for (int i = 0; i < 32; i++)
      do_write({8'(i * 7 + 3), 10'(i * 33)}, 2'b11, 16'(i * 16'h1357 ^ 16'h5AC3), i < 2);
    for (int i = 0; i < 32; i++)
      do_read({8'(i * 7 + 3), 10'(i * 33)}, 2'b11, i < 2);

    // single-lane writes, then every mask on read
    for (int i = 0; i < 32; i++)
      do_write({8'(i * 7 + 3), 10'(i * 33)}, (i % 2) ? 2'b10 : 2'b01, 16'(i * 16'h0F0F + 16'h2468), i == 5);
    for (int i = 0; i < 32; i++)
      for (int m = 1; m < 4; m++)
        do_read({8'(i * 7 + 3), 10'(i * 33)}, 2'(m), i == 6);

    // zero mask: write and read are no-ops
    access(1'b1, {8'd3, 10'd0}, 2'b00, 16'hFFFF, rd, rv, rdy);
    check(rdy == 1 && rv == 0, "R8 zero-mask write ignored", {rdy, rv}, {32'd1, 32'd0});
    check(snap_ctl[1] == IDLE_CTL, "R8 pins stay idle", snap_ctl[1], IDLE_CTL);
    access(1'b0, {8'd3, 10'd0}, 2'b00, 16'h0000, rd, rv, rdy);
    check(rdy == 1 && rv == 0, "R8 zero-mask read no response", {rdy, rv}, {32'd1, 32'd0});
    do_read({8'd3, 10'd0}, 2'b11, 1'b0);

    // request held valid while busy and changed after acceptance
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = {8'd9, 10'd777}; req_be = 2'b11; req_wdata = 16'hBEEF;
    @(posedge clk);
    @(negedge clk);
    req_wdata = 16'h1234; req_be = 2'b01;
    we_lo = 0;
    while (!req_ready) begin
      if (!sram_we_n) we_lo++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(we_lo == E_WP, "R9 single accept while busy", we_lo, E_WP);
    shadow[10'd777] = 16'hBEEF;
    do_read({8'd9, 10'd777}, 2'b11, 1'b0);

    repeat (4) @(negedge clk);
    check(contention == 0, "R6 no driver overlap (ns)", contention, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule